// File: doc/BRIEF.md
# Prioritised Event Interrupt Controller

This block gathers up to eight numbered event requests into a pending mask and raises a single fast-interrupt line toward a processor while any event is outstanding. Event sources pulse one bit each on an eight-bit input; several may pulse in the same cycle. Alongside the mask, the block keeps a register holding the number of the event that software should service next. Software reads that number over a simple register read port.

Software acknowledges events by writing to a clear address. Acknowledge writes are counted, and only every fourth one retires an event. Retirement removes the lowest-numbered pending slot. The reported number is then refreshed by scanning upward from the retired slot for the next pending one. The update rules for the reported number are deliberately lopsided. An arriving event replaces it only when the register reads zero or the newcomer is lower. After the last pending event retires, the register keeps its old value.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the pending mask and the acknowledge counter are zero, `irq_fast_o` is low, and the reported event number reads 0.
- R2: When one or more bits of `evt_i` are high in a cycle where the pending mask is empty, `irq_fast_o` is high from the next cycle on.
- R3: An arriving event number replaces the reported number only if the reported number is currently 0 or the arriving number is strictly lower; otherwise the reported number is unchanged.
- R4: All bits pulsed together on `evt_i` are recorded as pending, and only the lowest of them takes part in the R3 rule.
- R5: A write with `wr_en_i` high and `wr_addr_i` equal to 0x10 counts one acknowledge. Writes to any other address are not counted. Nothing is retired on the first three counted writes. On the fourth, the counter returns to zero.
- R6: On the fourth counted acknowledge, the lowest pending slot is cleared. The reported number becomes the first pending slot found scanning upward from it. If no slot remains pending, the reported number is left unchanged.
- R7: When a retirement leaves the pending mask empty and no event arrives in that cycle, `irq_fast_o` falls. At all other times it stays high exactly while some event is pending.
- R8: An event pulsed in the same cycle as the retirement of its own slot stays pending.
- R9: A read with `rd_en_i` high and `rd_addr_i` equal to 0x08 returns the reported event number in bits [2:0] of `rd_data_o` on the next cycle, with the upper bits zero. Any other read, or no read, gives zero on the next cycle.
- R10: A fourth counted acknowledge with an empty mask retires nothing but still returns the counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event request pulses, one bit per event number |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data, valid one cycle after the strobe |
| irq_fast_o | output | 1 | Fast-interrupt request to the processor |

## Verification
The assertions assume that `evt_i` and the strobes are known, not X, on every clock edge after reset. They also assume that each strobe covers exactly the cycle in which it is meant, so one held write counts once per cycle. The stimulus drives all inputs on the falling edge and returns them to zero one cycle later. Event pulses, acknowledge writes and reads are therefore single-cycle and never overlap by accident. The only deliberate overlap is an event pulsed in the same cycle as the fourth acknowledge.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int EVT_N  = 8;
    localparam int SLOT_W = $clog2(EVT_N);

    typedef logic [EVT_N-1:0]  evt_mask_t;
    typedef logic [SLOT_W-1:0] slot_t;

    // Result of a lowest-set-bit search over an event mask.
    typedef struct packed {
        logic  hit;
        slot_t slot;
    } pick_t;

    // What the read port returns on the next cycle.
    typedef enum logic [0:0] {
        RSEL_NONE = 1'b0,
        RSEL_NUM  = 1'b1
    } rsel_e;

    // One-hot mask for a slot number.
    function automatic evt_mask_t slot_onehot(input slot_t s);
        evt_mask_t m;
        m = '0;
        m[s] = 1'b1;
        return m;
    endfunction

    // Mask with every slot at or above s set.
    function automatic evt_mask_t upward_mask(input slot_t s);
        evt_mask_t m;
        for (int i = 0; i < EVT_N; i++) begin
            m[i] = (i >= int'(s));
        end
        return m;
    endfunction

endpackage

// File: rtl/evt_prio_pick.sv
module evt_prio_pick
    import evt_irq_pkg::*;
(
    input  evt_mask_t req_i,
    output pick_t     pick_o
);

    evt_mask_t first;
    slot_t     slot;

    // first[g] is set only for the lowest requesting slot.
    for (genvar g = 0; g < EVT_N; g++) begin : g_first
        if (g == 0) begin : g_base
            assign first[g] = req_i[0];
        end else begin : g_rest
            assign first[g] = req_i[g] & ~(|req_i[g-1:0]);
        end
    end

    always_comb begin
        slot = '0;
        for (int i = 0; i < EVT_N; i++) begin
            if (first[i]) begin
                slot = slot | SLOT_W'(i);
            end
        end
        pick_o.hit  = |req_i;
        pick_o.slot = slot;
    end

endmodule

// File: rtl/evt_ack_count.sv
module evt_ack_count #(
    parameter int ACK_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_i,
    output logic fire_o
);

    localparam int CNT_W = (ACK_LIMIT > 1) ? $clog2(ACK_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d  = cnt_q;
        fire_o = 1'b0;
        if (ack_i) begin
            if (cnt_q == LAST) begin
                cnt_d  = '0;
                fire_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5: the counter wraps to zero on the last acknowledge
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (ack_i && cnt_q == LAST) |=> (cnt_q == '0));

    // R5: each earlier acknowledge advances the counter by one
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (ack_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R5: without an acknowledge the counter holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> $stable(cnt_q));

    // R1: counter is zero right after reset
    a_r1_cnt_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt_q == '0));

endmodule

// File: rtl/evt_pend_store.sv
module evt_pend_store
    import evt_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_mask_t set_i,
    input  logic      clr_en_i,
    input  slot_t     clr_slot_i,
    output evt_mask_t pend_o
);

    evt_mask_t pend_q;
    evt_mask_t clr_mask;

    assign clr_mask = clr_en_i ? slot_onehot(clr_slot_i) : '0;

    // Set is applied after clear, so a new arrival wins over retirement.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | set_i;
        end
    end

    assign pend_o = pend_q;

    // R4/R8: every arriving bit is pending in the next cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    // R6: a retired slot that is not re-requested is gone
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_en_i && !set_i[clr_slot_i]) |=> !pend_q[$past(clr_slot_i)]);

    // R4: without a retirement no pending bit is lost
    a_r4_keep: assert property (@(posedge clk) disable iff (rst)
        !clr_en_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R1: mask empty right after reset
    a_r1_mask_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_q == '0));

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              ACK_LIMIT = 4,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h10,
    parameter logic [ADDR_W-1:0] NUM_ADDR  = 8'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_fast_o
);

    evt_mask_t pend;
    evt_mask_t remain;
    evt_mask_t scan_req;
    pick_t     pick_arr;
    pick_t     pick_pend;
    pick_t     pick_scan;
    logic      ack;
    logic      retire;
    logic      retire_hit;
    slot_t     num_q;
    slot_t     num_mid;
    slot_t     num_d;
    logic      irq_q;
    logic      irq_d;
    rsel_e     rsel;
    logic [DATA_W-1:0] rd_data_q;

    // Acknowledge counting
    assign ack = wr_en_i && (wr_addr_i == CLR_ADDR);

    evt_ack_count #(
        .ACK_LIMIT (ACK_LIMIT)
    ) u_ack (
        .clk    (clk),
        .rst    (rst),
        .ack_i  (ack),
        .fire_o (retire)
    );

    // Lowest arriving event, lowest pending slot, and forward scan
    evt_prio_pick u_pick_arr  (.req_i(evt_i),    .pick_o(pick_arr));
    evt_prio_pick u_pick_pend (.req_i(pend),     .pick_o(pick_pend));

    assign retire_hit = retire && pick_pend.hit;
    assign remain     = pend & ~slot_onehot(pick_pend.slot);
    assign scan_req   = remain & upward_mask(pick_pend.slot);

    evt_prio_pick u_pick_scan (.req_i(scan_req), .pick_o(pick_scan));

    // Pending mask
    evt_pend_store u_store (
        .clk        (clk),
        .rst        (rst),
        .set_i      (evt_i),
        .clr_en_i   (retire_hit),
        .clr_slot_i (pick_pend.slot),
        .pend_o     (pend)
    );

    // Reported event number: retirement first, then the arrival rule
    always_comb begin
        num_mid = num_q;
        if (retire_hit && pick_scan.hit) begin
            num_mid = pick_scan.slot;
        end
        num_d = num_mid;
        if (pick_arr.hit && ((num_mid == '0) || (pick_arr.slot < num_mid))) begin
            num_d = pick_arr.slot;
        end
    end

    // Fast-interrupt line
    always_comb begin
        irq_d = irq_q;
        if (pick_arr.hit && (pend == '0)) begin
            irq_d = 1'b1;
        end else if (retire_hit && (remain == '0) && !pick_arr.hit) begin
            irq_d = 1'b0;
        end
    end

    // Read port
    assign rsel = (rd_en_i && (rd_addr_i == NUM_ADDR)) ? RSEL_NUM : RSEL_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q     <= '0;
            irq_q     <= 1'b0;
            rd_data_q <= '0;
        end else begin
            num_q <= num_d;
            irq_q <= irq_d;
            case (rsel)
                RSEL_NUM: rd_data_q <= DATA_W'(num_q);
                default:  rd_data_q <= '0;
            endcase
        end
    end

    assign rd_data_o  = rd_data_q;
    assign irq_fast_o = irq_q;

    // R1: outputs idle right after reset
    a_r1_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_fast_o && num_q == '0));

    // R2: an arrival into an empty mask raises the line
    a_r2_raise: assert property (@(posedge clk) disable iff (rst)
        ((pend == '0) && (evt_i != '0)) |=> irq_fast_o);

    // R7: the line mirrors whether anything is pending
    a_r7_track: assert property (@(posedge clk) disable iff (rst)
        irq_fast_o == (pend != '0));

    // R3: the number only moves on an arrival or a retirement
    a_r3_num_hold: assert property (@(posedge clk) disable iff (rst)
        ((evt_i == '0) && !retire) |=> $stable(num_q));

    // R6: with no arrival, retirement reports the next pending slot
    a_r6_next: assert property (@(posedge clk) disable iff (rst)
        (retire_hit && pick_scan.hit && (evt_i == '0)) |=> (num_q == $past(pick_scan.slot)));

    // R9: read data follows the strobe by one cycle
    a_r9_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && rd_addr_i == NUM_ADDR) |=> (rd_data_o == DATA_W'($past(num_q))));

    // R9: no matching read gives zero
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_i && rd_addr_i == NUM_ADDR) |=> (rd_data_o == '0));

endmodule

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;

    localparam logic [7:0] CLR_A = 8'h10;
    localparam logic [7:0] NUM_A = 8'h08;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_i = '0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_addr_i = '0;
    logic       rd_en_i = 1'b0;
    logic [7:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_fast_o;

    int checks = 0;
    int fails  = 0;

    // Expected state, built from the requirements
    logic [7:0] m_pend;
    int         m_cnt;
    int         m_num;
    logic       m_irq;

    always #10 clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .irq_fast_o (irq_fast_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic model_step(input logic [7:0] set, input bit ack);
        if (ack) begin
            if (m_cnt == 3) begin
                m_cnt = 0;
                if (m_pend != 0) begin
                    int lo = 0;
                    for (int i = 7; i >= 0; i--) if (m_pend[i]) lo = i;
                    m_pend[lo] = 1'b0;
                    for (int j = lo; j < 8; j++) begin
                        if (m_pend[j]) begin
                            m_num = j;
                            break;
                        end
                    end
                    if (m_pend == 0) m_irq = 1'b0;
                end
            end else begin
                m_cnt++;
            end
        end
        if (set != 0) begin
            int a = 0;
            for (int i = 7; i >= 0; i--) if (set[i]) a = i;
            if (m_pend == 0) m_irq = 1'b1;
            m_pend = m_pend | set;
            if (m_num == 0 || a < m_num) m_num = a;
        end
    endtask

    // One cycle of stimulus; write address chosen by caller
    task automatic cycle(input logic [7:0] set, input bit wr, input logic [7:0] addr);
        @(negedge clk);
        evt_i     = set;
        wr_en_i   = wr;
        wr_addr_i = addr;
        @(negedge clk);
        evt_i   = '0;
        wr_en_i = 1'b0;
        model_step(set, wr && (addr == CLR_A));
    endtask

    task automatic pulse(input logic [7:0] set);
        cycle(set, 1'b0, 8'h00);
    endtask

    task automatic acks(input int n);
        for (int k = 0; k < n; k++) cycle(8'h00, 1'b1, CLR_A);
    endtask

    task automatic read_reg(input logic [7:0] addr, output int val);
        @(negedge clk);
        rd_en_i   = 1'b1;
        rd_addr_i = addr;
        @(negedge clk);
        rd_en_i = 1'b0;
        val = int'(rd_data_o);
    endtask

    task automatic check_state(input string req);
        int v;
        chk(req, "irq_fast_o", int'(irq_fast_o), int'(m_irq));
        read_reg(NUM_A, v);
        chk(req, "event number", v, m_num);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pend = '0;
        m_cnt  = 0;
        m_num  = 0;
        m_irq  = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "irq after reset", int'(irq_fast_o), 0);
        check_state("R1");
        pulse(8'b0010_1000);
        acks(3);
        check_state("R5 three acks retire nothing");
        acks(1);
        check_state("R6 fourth ack moves to slot 5");
        chk("R6", "expected number is 5", m_num, 5);
    endtask

    task automatic t_order();
        do_reset();
        pulse(8'b0001_0000);
        check_state("R2 single arrival raises line");
        pulse(8'b0100_0000);
        check_state("R3 higher arrival keeps number");
        pulse(8'b0000_0100);
        check_state("R3 lower arrival replaces number");
        chk("R3", "expected number is 2", m_num, 2);
    endtask

    task automatic t_multi();
        do_reset();
        pulse(8'b1010_0100);
        check_state("R4 lowest of a group wins");
        acks(4);
        check_state("R4 next of the group");
        acks(4);
        check_state("R4 last of the group");
        acks(4);
        check_state("R7 line falls when empty");
        chk("R6", "number kept after emptying", m_num, 7);
        pulse(8'b0100_0000);
        check_state("R3 arrival after stale number");
    endtask

    task automatic t_zero();
        do_reset();
        pulse(8'b0000_0001);
        check_state("R3 slot 0 arrives");
        pulse(8'b0010_0000);
        check_state("R3 zero register takes any arrival");
        chk("R3", "expected number is 5", m_num, 5);
    endtask

    task automatic t_collide();
        do_reset();
        pulse(8'b0000_1000);
        acks(3);
        cycle(8'b0000_1000, 1'b1, CLR_A);
        check_state("R8 arrival survives its own retirement");
        acks(4);
        check_state("R8 second retirement empties mask");
    endtask

    task automatic t_empty_ack();
        do_reset();
        acks(4);
        check_state("R10 empty retirement");
        pulse(8'b0000_0010);
        acks(3);
        check_state("R10 counter was wrapped");
        acks(1);
        check_state("R10 retire after wrap");
    endtask

    task automatic t_addr();
        int v;
        do_reset();
        pulse(8'b0000_0100);
        for (int k = 0; k < 4; k++) cycle(8'h00, 1'b1, 8'h11);
        check_state("R5 other address not counted");
        acks(4);
        check_state("R5 clear address counted");
        pulse(8'b0000_1000);
        read_reg(8'h09, v);
        chk("R9", "other read address", v, 0);
        @(negedge clk);
        chk("R9", "idle read data", int'(rd_data_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_multi();
        t_zero();
        t_collide();
        t_empty_ack();
        t_addr();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule